// File: doc/BRIEF.md
# Cell Accumulator Shift-and-Add Combiner

This block sits behind a bank of eight multiply-accumulate filter cells and turns their 26-bit accumulators into one 26-bit result bus. A 3-bit address picks one cell. A shift-add control then chooses between two paths. The first path passes the picked accumulator straight to the bus. The second path adds the picked accumulator to an internal 26-bit buffer that has been arithmetically shifted right by eight bits. Chaining passes of the second kind combines partial products into a result of wider precision.

The address and the control are registered once on entry. The buffer and the captured cell value are each written one edge later, so every result appears on the bus two rising edges after its address and control are presented. A cell value stays on the bus for as long as its address is held, which lets a slow memory latch it over several cycles. The upper and lower parts of the bus each have an active-low enable; a disabled part reads as zeros.

Top module: `sadd_out_stage`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the buffer, the captured cell value and the control history, so the bus reads all zeros after that edge.
- R2: When the registered shift-add control is low, the buffer is loaded with the picked cell accumulator alone, and its old contents are dropped.
- R3: When the registered shift-add control is high, the buffer is loaded with the picked accumulator plus the buffer's bits 25:8, sign-extended to 26 bits, which is (buffer >>> 8) + cell in two's complement modulo 2^26.
- R4: An address and control presented before rising edge k take effect at edge k+1, so their result is on the bus after edge k+1, which is two edges after they were presented.
- R5: The bus shows the captured cell value only when the control was low at both of the last two registered samples. Otherwise it shows the buffer.
- R6: While the registered address is unchanged from the previous cycle, the captured cell value keeps the value taken on the first cycle of that selection. A new address captures afresh, and so does the first selection after reset.
- R7: Address i selects the accumulator held in bits [26*i+25 : 26*i] of the flattened input vector, with i from 0 to 7.
- R8: oe_hi_n high forces bus bits 25:18 to zero, and oe_lo_n high forces bus bits 17:0 to zero. Both enables act combinationally, without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_flat | input | 208 | Eight 26-bit cell accumulators; cell i occupies bits 26*i+25:26*i |
| sel | input | 3 | Cell address |
| shift_add | input | 1 | High: add the shifted buffer; low: zero operand |
| oe_hi_n | input | 1 | Active-low enable for bus bits 25:18 |
| oe_lo_n | input | 1 | Active-low enable for bus bits 17:0 |
| sum | output | 26 | Result bus |

## Verification
The bench drives each address, control value and enable on a falling edge. A rising edge counted as k is the next rising edge after that falling edge. The accumulator vector is sampled at edge k+1, so the bus value the stimulus produces is due two ns after edge k+1, and the scoreboard stamps each expected item with that edge number. The monitor pops only the items whose stamp matches the current edge count. A result that lands one edge early or late is therefore compared against a different expectation and reported. The enables act combinationally, and they are still held when the monitor samples, so the monitor applies their masking to the same item.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  localparam int DEF_CELLS = 8;
  localparam int DEF_ACC_W = 26;
  localparam int DEF_SHIFT = 8;
  localparam int DEF_HI_W  = 8;

  typedef enum logic {SRC_BUF = 1'b0, SRC_CELL = 1'b1} out_src_e;
endpackage

// File: rtl/sadd_ctrl_pipe.sv
module sadd_ctrl_pipe #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shadd_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              add_en,
  output logic              new_sel,
  output logic              cell_src
);
  logic [ADDR_W-1:0] addr_qq;
  logic              shadd_q, shadd_qq;
  logic              live_q, live_qq;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      addr_qq  <= '0;
      shadd_q  <= 1'b0;
      shadd_qq <= 1'b0;
      live_q   <= 1'b0;
      live_qq  <= 1'b0;
    end else begin
      addr_q   <= addr_i;
      addr_qq  <= addr_q;
      shadd_q  <= shadd_i;
      shadd_qq <= shadd_q;
      live_q   <= 1'b1;
      live_qq  <= live_q;
    end
  end

  // a selection is new on the first cycle after reset or when the address moved
  assign new_sel  = !live_qq || (addr_q != addr_qq);
  assign add_en   = shadd_q;
  assign cell_src = !shadd_q && !shadd_qq;

  // R4: the control reaches its second stage exactly two edges after entry
  p_ctrl_delay_r4: assert property (@(posedge clk) disable iff (rst)
    live_qq |-> (shadd_qq == $past(shadd_i, 2)));

  // R6: a held address is never flagged as a new selection once history exists
  p_repeat_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (live_q && live_qq && addr_i == addr_q) |=> !new_sel);
endmodule

// File: rtl/sadd_cell_pick.sv
module sadd_cell_pick #(
  parameter int CELLS  = 8,
  parameter int ACC_W  = 26,
  parameter int ADDR_W = 3
) (
  input  logic [CELLS*ACC_W-1:0] acc_flat,
  input  logic [ADDR_W-1:0]      addr,
  output logic [ACC_W-1:0]       picked
);
  logic [ACC_W-1:0] cell_acc [CELLS];

  for (genvar i = 0; i < CELLS; i++) begin : g_unpack
    assign cell_acc[i] = acc_flat[i*ACC_W +: ACC_W];
  end

  always_comb begin
    picked = '0;
    for (int j = 0; j < CELLS; j++) begin
      if (addr == ADDR_W'(j)) picked = cell_acc[j];
    end
  end
endmodule

// File: rtl/sadd_combiner.sv
module sadd_combiner #(
  parameter int ACC_W = 26,
  parameter int SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [ACC_W-1:0] picked,
  output logic [ACC_W-1:0] buf_q,
  output logic [ACC_W-1:0] feedback
);
  // top ACC_W-SHIFT bits of the buffer, sign-extended back to full width
  function automatic logic [ACC_W-1:0] shifted_operand(input logic [ACC_W-1:0] b,
                                                       input logic en);
    logic [ACC_W-1:0] r;
    r = {{SHIFT{b[ACC_W-1]}}, b[ACC_W-1:SHIFT]};
    return en ? r : '0;
  endfunction

  assign feedback = shifted_operand(buf_q, add_en);

  always_ff @(posedge clk) begin
    if (rst) buf_q <= '0;
    else     buf_q <= picked + feedback;
  end

  // R2: with the control low the old buffer has no influence
  p_plain_load_r2: assert property (@(posedge clk) disable iff (rst)
    !add_en |=> (buf_q == $past(picked)));

  // R3: with the control high the new buffer exceeds the cell by the shifted old buffer
  p_shift_add_r3: assert property (@(posedge clk) disable iff (rst)
    add_en |=> ((buf_q - $past(picked)) ==
                {{SHIFT{$past(buf_q[ACC_W-1])}}, $past(buf_q[ACC_W-1:SHIFT])}));
endmodule

// File: rtl/sadd_hold.sv
module sadd_hold
  import sadd_pkg::*;
#(
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             cell_src,
  input  logic [ACC_W-1:0] picked,
  output logic [ACC_W-1:0] cap_q,
  output out_src_e         src_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      src_q <= SRC_BUF;
    end else begin
      if (capture) cap_q <= picked;
      src_q <= cell_src ? SRC_CELL : SRC_BUF;
    end
  end

  // R6: a repeated selection leaves the captured value alone
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(cap_q));

  // R6: a new selection takes the picked accumulator
  p_fresh_capture_r6: assert property (@(posedge clk) disable iff (rst)
    capture |=> (cap_q == $past(picked)));
endmodule

// File: rtl/sadd_out_stage.sv
module sadd_out_stage
  import sadd_pkg::*;
#(
  parameter int CELLS = DEF_CELLS,
  parameter int ACC_W = DEF_ACC_W,
  parameter int SHIFT = DEF_SHIFT,
  parameter int HI_W  = DEF_HI_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CELLS*ACC_W-1:0]       acc_flat,
  input  logic [$clog2(CELLS)-1:0]     sel,
  input  logic                         shift_add,
  input  logic                         oe_hi_n,
  input  logic                         oe_lo_n,
  output logic [ACC_W-1:0]             sum
);
  localparam int ADDR_W = $clog2(CELLS);
  localparam int LO_W   = ACC_W - HI_W;

  logic [ADDR_W-1:0] addr_q;
  logic              add_en, new_sel, cell_src;
  logic [ACC_W-1:0]  picked, buf_q, feedback, cap_q, sum_raw;
  out_src_e          src_q;

  sadd_ctrl_pipe #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .addr_i(sel), .shadd_i(shift_add),
    .addr_q(addr_q), .add_en(add_en), .new_sel(new_sel), .cell_src(cell_src)
  );

  sadd_cell_pick #(.CELLS(CELLS), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_pick (
    .acc_flat(acc_flat), .addr(addr_q), .picked(picked)
  );

  sadd_combiner #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_comb (
    .clk(clk), .rst(rst), .add_en(add_en), .picked(picked),
    .buf_q(buf_q), .feedback(feedback)
  );

  sadd_hold #(.ACC_W(ACC_W)) u_hold (
    .clk(clk), .rst(rst), .capture(new_sel), .cell_src(cell_src),
    .picked(picked), .cap_q(cap_q), .src_q(src_q)
  );

  assign sum_raw = (src_q == SRC_CELL) ? cap_q : buf_q;

  always_comb begin
    sum = sum_raw;
    if (oe_hi_n) sum[ACC_W-1:LO_W] = '0;
    if (oe_lo_n) sum[LO_W-1:0]     = '0;
  end

  // R1: the first cycle out of reset presents an empty result
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sum_raw == '0));

  // R5: two low control samples hand the bus to the captured cell
  p_cell_path_r5: assert property (@(posedge clk) disable iff (rst)
    cell_src |=> (sum_raw == cap_q));

  // R5: any high control sample in the window hands the bus to the buffer
  p_buf_path_r5: assert property (@(posedge clk) disable iff (rst)
    !cell_src |=> (sum_raw == buf_q));

  // R8: a disabled part of the bus reads zero
  always_comb begin
    if (oe_hi_n) p_hi_off_r8: assert (sum[ACC_W-1:LO_W] == '0);
    if (oe_lo_n) p_lo_off_r8: assert (sum[LO_W-1:0] == '0);
  end
endmodule

// File: tb/sim_sadd_out_stage.sv
module sim_sadd_out_stage;
  localparam int N = 8;
  localparam int W = 26;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N*W-1:0] acc_flat = '0;
  logic [2:0]     sel = '0;
  logic           shift_add = 1'b0;
  logic           oe_hi_n = 1'b0;
  logic           oe_lo_n = 1'b0;
  logic [W-1:0]   sum;

  sadd_out_stage u0 (
    .clk(clk), .rst(rst), .acc_flat(acc_flat), .sel(sel), .shift_add(shift_add),
    .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n), .sum(sum)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    logic [W-1:0] val;
    string       tag;
  } item_t;

  item_t        q[$];
  int           cyc = 0;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  logic [W-1:0] cv [N];
  // reference state, written the bench's own way
  logic [W-1:0] r_buf, r_cap;
  logic [2:0]   h_a1, h_a2;
  bit           h_s1, h_s2, h_v1, h_v2;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops every item due at this edge, two ns after it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (sum !== it.val) begin
          n_bad++;
          $display("FAIL %s: sum=%h expected %h (edge %0d)", it.tag, sum, it.val, cyc);
        end
      end
    end
  end

  task automatic model_clear();
    r_buf = '0; r_cap = '0; h_a1 = '0; h_a2 = '0;
    h_s1 = 0; h_s2 = 0; h_v1 = 0; h_v2 = 0;
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1; oe_hi_n = 1'b0; oe_lo_n = 1'b0;
    model_clear();
    q.push_back('{due: cyc + 1, val: '0, tag: tag});
  endtask

  task automatic drive(input logic [2:0] a, input bit s, input bit oh, input bit ol,
                       input bit chk, input string tag);
    logic [W-1:0] shifted, exp;
    bit           show_cell;
    @(negedge clk);
    rst = 1'b0; sel = a; shift_add = s; oe_hi_n = oh; oe_lo_n = ol;
    for (int i = 0; i < N; i++) acc_flat[i*W +: W] = cv[i];
    // the coming edge finishes the work of the previous inputs
    shifted = W'($signed(r_buf) >>> 8);
    r_buf   = cv[h_a1] + (h_s1 ? shifted : '0);
    if (!h_v2 || h_a1 != h_a2) r_cap = cv[h_a1];
    show_cell = !h_s1 && !h_s2;
    exp = show_cell ? r_cap : r_buf;
    if (oh) exp[25:18] = '0;
    if (ol) exp[17:0]  = '0;
    h_a2 = h_a1; h_a1 = a; h_s2 = h_s1; h_s1 = s; h_v2 = h_v1; h_v1 = 1;
    if (chk) q.push_back('{due: cyc + 1, val: exp, tag: tag});
  endtask

  initial begin
    for (int i = 0; i < N; i++) cv[i] = W'(i * 26'h0011111 + 26'h5);
    model_clear();
    repeat (2) @(negedge clk);

    // R1: bus empty right after reset
    do_reset("R1");

    // R7, R4: a new cell each cycle in direct mode, due two edges later
    for (int i = 0; i < N; i++) drive(3'(i), 0, 0, 0, 1, "R7");
    drive(3'd7, 0, 0, 0, 1, "R4");

    // R6: hold the address while its accumulator moves
    drive(3'd3, 0, 0, 0, 1, "R6");
    for (int k = 0; k < 4; k++) begin
      cv[3] = cv[3] + 26'd100;
      drive(3'd3, 0, 0, 0, 1, "R6");
    end
    drive(3'd4, 0, 0, 0, 1, "R6");
    drive(3'd4, 0, 0, 0, 1, "R6");

    // R2, R3: two-pass combine, positive first partial
    cv[5] = 26'h03ABCDE; cv[6] = 26'h0001234;
    drive(3'd5, 1, 0, 0, 1, "R5");
    drive(3'd5, 0, 0, 0, 1, "R2");
    drive(3'd6, 1, 0, 0, 1, "R2");
    drive(3'd6, 1, 0, 0, 1, "R3");
    drive(3'd0, 0, 0, 0, 1, "R3");
    drive(3'd0, 0, 0, 0, 1, "R5");
    drive(3'd1, 0, 0, 0, 1, "R5");

    // R3: negative first partial, three passes
    cv[5] = 26'h2F00000; cv[6] = 26'h0000040; cv[7] = 26'h3FFFFF0;
    drive(3'd5, 0, 0, 0, 1, "R2");
    drive(3'd6, 1, 0, 0, 1, "R5");
    drive(3'd7, 1, 0, 0, 1, "R3");
    drive(3'd2, 1, 0, 0, 1, "R3");
    drive(3'd2, 0, 0, 0, 1, "R3");
    drive(3'd2, 0, 0, 0, 1, "R5");

    // R5: a single high sample forces the buffer onto the bus
    drive(3'd1, 1, 0, 0, 1, "R5");
    drive(3'd1, 0, 0, 0, 1, "R5");
    drive(3'd1, 0, 0, 0, 1, "R5");

    // R8: each enable pattern on a held cell
    drive(3'd2, 0, 0, 0, 1, "R8");
    drive(3'd2, 0, 1, 0, 1, "R8");
    drive(3'd2, 0, 0, 1, 1, "R8");
    drive(3'd2, 0, 1, 1, 1, "R8");
    drive(3'd2, 0, 0, 0, 1, "R8");

    // R1: reset in the middle of a run
    do_reset("R1");
    drive(3'd6, 0, 0, 0, 1, "R1");
    drive(3'd6, 0, 0, 0, 1, "R6");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_bad++; n_chk++;
      $display("FAIL R4: %0d results never arrived, expected 0", q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run still busy at edge %0d, expected end", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule